// File: doc/BRIEF.md
# Synchronous Serial Port Clock Generator

This block produces the transmit and receive bit-clock enables for two synchronous serial ports. All of them come from a single base clock. A shared 8-bit timer constant divides the base clock into a main internal tick. Two independent power-of-two prescalers then derive an internal transmit tick and an internal receive tick from it.

Each port has its own receive-source and transmit-source selectors. The receive side takes rising edges of the port's line clock, either raw or noise-filtered, or it takes the internal receive tick. The transmit side takes the line clock, the internal transmit tick, or the port's own selected receive enable. A per-port drive enable puts a clock made from the internal transmit tick onto that port's line clock output.

Every output enable is a single-cycle pulse in the base clock domain. Serial shifting and framing logic consumes these pulses as clock enables. Line clock inputs are asynchronous and are synchronized inside the block.

Top module: `sclk_gen`

## Requirements
- R1: The main tick repeats every `tmc_i` base clock cycles for `tmc_i` from 1 to 255. A `tmc_i` of 0 gives a period of 256 cycles.
- R2: The internal transmit tick repeats every (main period × 2^`tx_exp_i`) cycles, for exponents 0 to 7. An exponent of 0 passes every main tick through.
- R3: The internal receive tick repeats every (main period × 2^`rx_exp_i`) cycles. It is set independently of the transmit exponent.
- R4: The receive select for port p is the 2-bit field `rx_sel_i[2p+1:2p]`. Its codes are:
  - 0: a one-cycle pulse for each rising edge of the line clock, visible 2 cycles after the rise is first sampled.
  - 1: the noise-filtered line clock.
  - 2: the internal receive tick.
  - 3: behaves as 0.
- R5: The noise filter accepts a new line level only after it has been sampled at that level on 3 consecutive cycles. A high level held for 3 cycles gives a filtered receive pulse 5 cycles after it is first sampled. A high level held for 2 cycles gives no filtered pulse.
- R6: The transmit select for port p is the 2-bit field `tx_sel_i[2p+1:2p]`. Its codes are:
  - 0: line clock rising edges, with the same timing as in R4.
  - 1: the internal transmit tick.
  - 2: that port's receive enable.
  - 3: behaves as 0.
- R7: `line_oe_o[p]` equals `drv_en_i[p]`. While it is set, `line_clk_o[p]` toggles once per internal transmit tick. While it is clear, `line_clk_o[p]` is 0.
- R8: A change to `tmc_i` or to an exponent takes effect only when the current interval reaches its terminal count. The interval in progress finishes at its old length.
- R9: The two ports are independent. One port's selects, drive enable and line clock do not affect the other port's outputs.
- R10: During and right after reset, all enables, `line_clk_o` and `line_oe_o` (with `drv_en_i` clear) are 0. No enable stays high for two cycles unless the source tick itself repeats every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmc_i | input | 8 | Timer constant; 0 means 256 |
| tx_exp_i | input | 3 | Transmit prescaler exponent |
| rx_exp_i | input | 3 | Receive prescaler exponent |
| rx_sel_i | input | 4 | Receive source select, 2 bits per port |
| tx_sel_i | input | 4 | Transmit source select, 2 bits per port |
| drv_en_i | input | 2 | Per-port enable to drive the internal clock onto the line |
| line_clk_i | input | 2 | Asynchronous line clocks from the pins |
| line_clk_o | output | 2 | Line clock driven from the internal transmit tick |
| line_oe_o | output | 2 | Line clock output enable |
| rx_en_o | output | 2 | Receive bit-clock enable pulses |
| tx_en_o | output | 2 | Transmit bit-clock enable pulses |

## Verification
The assertions assume the following about the inputs:
- `tmc_i` stays constant across the cycle after a main tick, so the minimum-gap property sees the value that was reloaded.
- Each line clock is a plain level that may switch on any cycle.

To stay within these assumptions, the stimulus changes divider settings only on the falling edge. It moves line clocks in whole-cycle steps, with gaps long enough for the filter to settle between probes. Divider changes in the middle of an interval are made on purpose, to observe that the interval in progress finishes at its old length.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    RX_LINE  = 2'd0,
    RX_FILT  = 2'd1,
    RX_INT   = 2'd2,
    RX_RSVD  = 2'd3
  } rx_src_e;

  typedef enum logic [SEL_W-1:0] {
    TX_LINE  = 2'd0,
    TX_INT   = 2'd1,
    TX_RXCLK = 2'd2,
    TX_RSVD  = 2'd3
  } tx_src_e;
endpackage

// File: rtl/sclk_main_div.sv
module sclk_main_div #(
  parameter int unsigned TMC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMC_W-1:0] tmc_i,
  output logic             tick_o
);
  logic [TMC_W-1:0] cnt_q;
  logic             run_q;

  assign tick_o = run_q && (cnt_q == '0);

  // reload at terminal count; 0 - 1 wraps to full range (0 means 2**TMC_W)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (tick_o)     cnt_q <= tmc_i - 1'b1;
      else if (run_q) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_min_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || $past(tmc_i) == TMC_W'(1)));
endmodule

// File: rtl/sclk_pow2_pre.sv
module sclk_pow2_pre #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_tick_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((CNT_W+1)'(1) << exp_i) - 1'b1;
  assign tick_o = in_tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (in_tick_i) cnt_q <= (cnt_q == '0) ? lim : cnt_q - 1'b1;
  end

  assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_o) && $past(exp_i) == '0 && in_tick_i) |-> tick_o);
endmodule

// File: rtl/sclk_line_in.sv
module sclk_line_in #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic filt_rise_o
);
  localparam int unsigned FC_W = $clog2(FILT_LEN);

  logic            s1_q, s2_q, s2_prev_q;
  logic            filt_q, filt_prev_q;
  logic [FC_W-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q        <= 1'b0;
      s2_q        <= 1'b0;
      s2_prev_q   <= 1'b0;
      filt_q      <= 1'b0;
      filt_prev_q <= 1'b0;
      fcnt_q      <= '0;
    end else begin
      s1_q        <= line_i;
      s2_q        <= s1_q;
      s2_prev_q   <= s2_q;
      filt_prev_q <= filt_q;
      if (s2_q == filt_q) begin
        fcnt_q <= '0;
      end else if (fcnt_q == FC_W'(FILT_LEN-1)) begin
        filt_q <= s2_q;
        fcnt_q <= '0;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  assign rise_o      = s2_q & ~s2_prev_q;
  assign filt_rise_o = filt_q & ~filt_prev_q;

  assert_filt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(fcnt_q) == FC_W'(FILT_LEN-1) && $past(s2_q) == filt_q));

  assert_rise_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int unsigned NP       = 2,
  parameter int unsigned TMC_W    = 8,
  parameter int unsigned EXP_W    = 3,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TMC_W-1:0]    tmc_i,
  input  logic [EXP_W-1:0]    tx_exp_i,
  input  logic [EXP_W-1:0]    rx_exp_i,
  input  logic [NP*SEL_W-1:0] rx_sel_i,
  input  logic [NP*SEL_W-1:0] tx_sel_i,
  input  logic [NP-1:0]       drv_en_i,
  input  logic [NP-1:0]       line_clk_i,
  output logic [NP-1:0]       line_clk_o,
  output logic [NP-1:0]       line_oe_o,
  output logic [NP-1:0]       rx_en_o,
  output logic [NP-1:0]       tx_en_o
);
  logic main_tick, int_tx_tick, int_rx_tick;
  logic drv_clk_q;

  sclk_main_div #(.TMC_W(TMC_W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmc_i(tmc_i), .tick_o(main_tick)
  );

  sclk_pow2_pre #(.EXP_W(EXP_W)) u_tx_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_tick_i(main_tick),
    .exp_i(tx_exp_i), .tick_o(int_tx_tick)
  );

  sclk_pow2_pre #(.EXP_W(EXP_W)) u_rx_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_tick_i(main_tick),
    .exp_i(rx_exp_i), .tick_o(int_rx_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          drv_clk_q <= 1'b0;
    else if (int_tx_tick) drv_clk_q <= ~drv_clk_q;
  end

  assert_drv_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_clk_q != $past(drv_clk_q)) |-> $past(int_tx_tick));

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic    line_rise, line_filt_rise;
    rx_src_e rx_sel;
    tx_src_e tx_sel;

    sclk_line_in #(.FILT_LEN(FILT_LEN)) u_line (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_clk_i[p]),
      .rise_o(line_rise), .filt_rise_o(line_filt_rise)
    );

    assign rx_sel = rx_src_e'(rx_sel_i[p*SEL_W +: SEL_W]);
    assign tx_sel = tx_src_e'(tx_sel_i[p*SEL_W +: SEL_W]);

    always_comb begin
      unique case (rx_sel)
        RX_FILT: rx_en_o[p] = line_filt_rise;
        RX_INT:  rx_en_o[p] = int_rx_tick;
        default: rx_en_o[p] = line_rise;
      endcase
    end

    always_comb begin
      unique case (tx_sel)
        TX_INT:   tx_en_o[p] = int_tx_tick;
        TX_RXCLK: tx_en_o[p] = rx_en_o[p];
        default:  tx_en_o[p] = line_rise;
      endcase
    end

    assign line_oe_o[p]  = drv_en_i[p];
    assign line_clk_o[p] = drv_en_i[p] & drv_clk_q;

    assert_tx_follows_rx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_sel == TX_RXCLK && rx_sel == RX_INT) |-> (tx_en_o[p] == int_rx_tick));
  end
endmodule

// File: tb/tb_sclk_gen.sv
`timescale 1ns/1ps
module tb_sclk_gen;
  localparam int NP = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] tmc_i = 8'd1;
  logic [2:0] tx_exp_i = '0, rx_exp_i = '0;
  logic [3:0] rx_sel_i = '0, tx_sel_i = '0;
  logic [1:0] drv_en_i = '0, line_clk_i = '0;
  logic [1:0] line_clk_o, line_oe_o, rx_en_o, tx_en_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  sclk_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmc_i(tmc_i), .tx_exp_i(tx_exp_i),
    .rx_exp_i(rx_exp_i), .rx_sel_i(rx_sel_i), .tx_sel_i(tx_sel_i),
    .drv_en_i(drv_en_i), .line_clk_i(line_clk_i), .line_clk_o(line_clk_o),
    .line_oe_o(line_oe_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o)
  );

  // {tmc, tx_exp, rx_exp}
  localparam int NV = 7;
  localparam logic [13:0] VEC [NV] = '{
    {8'd1,   3'd0, 3'd0},
    {8'd3,   3'd1, 3'd2},
    {8'd5,   3'd0, 3'd3},
    {8'd0,   3'd0, 3'd0},
    {8'd2,   3'd7, 3'd0},
    {8'd200, 3'd2, 3'd1},
    {8'd7,   3'd3, 3'd5}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic get_en(input int port, input bit is_tx);
    return is_tx ? tx_en_o[port] : rx_en_o[port];
  endfunction

  // negedges until the next pulse (>=1), or -1 on timeout
  task automatic wait_pulse(input int port, input bit is_tx, output int n);
    n = -1;
    for (int i = 1; i <= 70000; i++) begin
      @(negedge clk_i);
      if (get_en(port, is_tx)) begin n = i; break; end
    end
  endtask

  task automatic measure(input int port, input bit is_tx, output int per);
    int d;
    wait_pulse(port, is_tx, d);
    wait_pulse(port, is_tx, per);
  endtask

  // raise line at a negedge for `hold` cycles; return first pulse sample and pulse count
  task automatic line_probe(input int port, input bit is_tx, input int hold,
                            output int first, output int cnt);
    first = 0; cnt = 0;
    @(negedge clk_i);
    line_clk_i[port] = 1'b1;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk_i);
      if (get_en(port, is_tx)) begin
        cnt++;
        if (first == 0) first = i;
      end
      if (i == hold) line_clk_i[port] = 1'b0;
    end
    repeat (6) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int per, f, c, n;
    logic prev;
    rx_sel_i = 4'b1010;   // R10 check with internal sources selected
    tx_sel_i = 4'b0101;
    repeat (3) @(negedge clk_i);
    chk("R10 reset enables", int'({rx_en_o, tx_en_o}), 0);
    chk("R10 reset line outputs", int'({line_clk_o, line_oe_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R3: divider table, port 0 internal sources
    for (int v = 0; v < NV; v++) begin
      int m, et, er;
      tmc_i    = VEC[v][13:6];
      tx_exp_i = VEC[v][5:3];
      rx_exp_i = VEC[v][2:0];
      m  = (VEC[v][13:6] == 0) ? 256 : int'(VEC[v][13:6]);
      et = m << VEC[v][5:3];
      er = m << VEC[v][2:0];
      measure(0, 1'b1, per);
      chk($sformatf("R1/R2 tx period vec%0d", v), per, et);
      measure(0, 1'b0, per);
      chk($sformatf("R3 rx period vec%0d", v), per, er);
    end

    // R6: tx from port receive clock (internal rx)
    tmc_i = 8'd3; tx_exp_i = 3'd0; rx_exp_i = 3'd2;
    tx_sel_i[1:0] = 2'd2;
    measure(0, 1'b1, per);
    chk("R6 tx from rx clock period", per, 12);

    // R8: change tmc mid interval
    tmc_i = 8'd10; tx_sel_i[1:0] = 2'd1; tx_exp_i = 3'd0;
    measure(0, 1'b1, per);
    c = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (tx_en_o[0]) c++;
    end
    tmc_i = 8'd4;
    wait_pulse(0, 1'b1, n);
    chk("R8 old tmc interval completes", n + 3 + c * 100, 10);
    wait_pulse(0, 1'b1, n);
    chk("R8 new tmc interval", n, 4);

    // R8: change exponent mid interval
    tmc_i = 8'd2; tx_exp_i = 3'd3;
    measure(0, 1'b1, per);
    repeat (2) @(negedge clk_i);
    tx_exp_i = 3'd0;
    wait_pulse(0, 1'b1, n);
    chk("R8 old exponent interval completes", n + 2, 16);
    wait_pulse(0, 1'b1, n);
    chk("R8 new exponent interval", n, 2);

    // R7: drive enable on port 0 only
    tmc_i = 8'd1; tx_exp_i = 3'd0;
    drv_en_i = 2'b01;
    @(negedge clk_i);
    prev = line_clk_o[0];
    c = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (line_clk_o[0] != prev) c++;
      prev = line_clk_o[0];
    end
    chk("R7 line clock toggles per tx tick", c, 8);
    chk("R7 oe follows drive enable", int'(line_oe_o), 1);
    chk("R7/R9 undriven port line clock low", int'(line_clk_o[1]), 0);
    drv_en_i = 2'b00;
    @(negedge clk_i);
    chk("R7 disabled line clock", int'({line_clk_o, line_oe_o}), 0);

    // R9: port 1 on idle line while port 0 runs internal
    rx_sel_i = {2'd0, 2'd2};
    tx_sel_i = {2'd0, 2'd1};
    tmc_i = 8'd2;
    c = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (rx_en_o[1] || tx_en_o[1]) c++;
    end
    chk("R9 port 1 idle while port 0 pulses", c, 0);

    // R4: raw line edge
    rx_sel_i = {2'd0, 2'd0}; tx_sel_i = {2'd0, 2'd0};
    line_probe(0, 1'b0, 4, f, c);
    chk("R4 raw rise latency", f, 2);
    chk("R4/R10 raw rise single pulse", c, 1);
    line_probe(0, 1'b0, 2, f, c);
    chk("R4 raw accepts short pulse", c, 1);

    // R4: reserved code 3 behaves as line
    rx_sel_i[3:2] = 2'd3;
    line_probe(1, 1'b0, 4, f, c);
    chk("R4 rsvd code latency", f, 2);

    // R5: noise filter
    rx_sel_i[1:0] = 2'd1;
    line_probe(0, 1'b0, 2, f, c);
    chk("R5 two-cycle glitch rejected", c, 0);
    line_probe(0, 1'b0, 3, f, c);
    chk("R5 three-cycle level accepted latency", f, 5);
    chk("R5 filtered single pulse", c, 1);

    // R6: tx line, rx-clock (filtered) and reserved code
    tx_sel_i[1:0] = 2'd2;
    line_probe(0, 1'b1, 4, f, c);
    chk("R6 tx via filtered rx latency", f, 5);
    tx_sel_i[1:0] = 2'd0;
    line_probe(0, 1'b1, 4, f, c);
    chk("R6 tx line latency", f, 2);
    tx_sel_i[3:2] = 2'd3;
    line_probe(1, 1'b1, 4, f, c);
    chk("R6 tx rsvd code latency", f, 2);

    // R9: port 0 line does not reach port 1
    rx_sel_i[3:2] = 2'd0;
    line_probe(0, 1'b0, 4, f, c);
    chk("R9 port 0 line on port 0", c, 1);
    line_probe(0, 1'b1, 4, f, n);
    c = 0;
    line_clk_i[0] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (rx_en_o[1]) c++;
    end
    line_clk_i[0] = 1'b0;
    chk("R9 port 0 line absent on port 1", c, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule